// File: doc/BRIEF.md
# Transport-Triggered Move Datapath

This block is a datapath driven only by data transports. Each cycle, every transport bus receives one move slot. A slot holds a valid bit, a source socket code, a destination socket code and an immediate value. The instruction never names an operation. Computation happens as a side effect: a move that lands on one of the ALU trigger sockets starts an operation, and the operation is chosen by which trigger socket was addressed. The ALU's operand port keeps its value between operations, so repeated triggers can reuse it like an accumulator. Results are collected by moving the result socket into a register.

All buses carry their moves in the same clock cycle. Sources are read from the state present at the start of the cycle. The register file has one read port per bus and one write port per bus, so its port count scales with the bus count. A debug port reads any register directly, without a move.

Top module: `move_datapath`

## Requirements
- R1: After reset, every register, the ALU operand port and the ALU result port hold zero, and the conflict output is low.
- R2: Source code 31 places the slot's immediate value on the bus. Destination codes 0 to NUM_REGS-1 write register k. The written value is visible on the debug read port after the next rising clock edge.
- R3: Source codes 0 to NUM_REGS-1 read register k as it stood before this cycle's writes, so two buses can swap two registers in one cycle.
- R4: Destination code 16 latches the bus value into the ALU operand port, and source code 17 reads that port back.
- R5: Destination codes 20, 21, 22 and 23 trigger ADD, SUB (operand minus bus value), AND and OR, each computed on the operand port and the bus value. Source code 16 returns the result from the cycle after the trigger move.
- R6: A read of source 16 in the same cycle as a trigger move returns the result from before that trigger.
- R7: If the operand port and a trigger socket are written in the same cycle, the operation uses the newly written operand value.
- R8: The operand port keeps its value across any number of triggers until it is written again.
- R9: When two valid moves in one cycle target the same register, the operand port, or the trigger port (any of codes 20 to 23), the higher-numbered bus wins. The conflict output is then high for exactly the following cycle.
- R10: A move with its valid bit clear changes no state. Destination codes outside the map are discarded and never raise a conflict. Source codes outside the map read as zero.
- R11: All buses complete their moves in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | NUM_BUS | Valid bit of each bus's move slot |
| slot_src | input | NUM_BUS*5 | Source socket code per bus; bus b uses bits [5b+4:5b] |
| slot_dst | input | NUM_BUS*5 | Destination socket code per bus; bus b uses bits [5b+4:5b] |
| slot_imm | input | NUM_BUS*DATA_W | Immediate value per bus, used when the source code is 31 |
| dbg_addr | input | clog2(NUM_REGS) | Register index for the debug read |
| dbg_data | output | DATA_W | Combinational contents of the addressed register |
| conflict | output | 1 | High for one cycle after a cycle with a destination clash |

## Verification
Two things can land in the same cycle: a trigger move and a move that reads the ALU result socket, and an operand write together with a trigger. The bench issues both pairs on separate buses in a single slot cycle. It then reads the captured registers through the debug port. A same-cycle result read must hold the value from before the trigger, and a later read must hold the new sum. A same-cycle operand write must appear in the sum that the trigger produces. Destination clashes are also provoked on purpose, on a register and on the trigger port. The bench checks which bus won and that the conflict pulse lasts exactly one cycle.

// File: rtl/move_pkg.sv
package move_pkg;

    // Socket codes are fixed at five bits; the register range sits at the bottom.
    localparam int SEL_W = 5;
    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t SRC_RESULT    = 5'd16;
    localparam sel_t SRC_OPERAND   = 5'd17;
    localparam sel_t SRC_IMM       = 5'd31;
    localparam sel_t DST_OPERAND   = 5'd16;
    localparam sel_t DST_TRIG_BASE = 5'd20;   // 20..23, low two bits pick the op

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        DK_NONE,
        DK_REG,
        DK_OPERAND,
        DK_TRIGGER
    } dst_kind_e;

    function automatic dst_kind_e classify_dst(input sel_t code, input int nregs);
        if (int'(code) < nregs)                              return DK_REG;
        if (code == DST_OPERAND)                             return DK_OPERAND;
        if (code[SEL_W-1:2] == DST_TRIG_BASE[SEL_W-1:2])     return DK_TRIGGER;
        return DK_NONE;
    endfunction

endpackage

// File: rtl/move_regfile.sv
module move_regfile
    import move_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 8,
    parameter int NUM_PORTS = 2,
    localparam int RA_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0][RA_W-1:0]       rd_addr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]     rd_data,
    input  logic [NUM_PORTS-1:0]                 wr_en,
    input  logic [NUM_PORTS-1:0][RA_W-1:0]       wr_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wr_data,
    input  logic [RA_W-1:0]                      dbg_addr,
    output logic [DATA_W-1:0]                    dbg_data
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    // Ascending port order: the last enabled port for an address takes effect.
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en[p]) begin
                st_d.regs[wr_addr[p]] = wr_data[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        assign rd_data[p] = st_q.regs[rd_addr[p]];
    end

    assign dbg_data = st_q.regs[dbg_addr];

    // R10: no enabled write port, no change
    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(st_q.regs));

    // R9: the top port always lands its value
    p_top_port_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[NUM_PORTS-1] |=>
            (st_q.regs[$past(wr_addr[NUM_PORTS-1])] == $past(wr_data[NUM_PORTS-1])));

endmodule

// File: rtl/move_alu_fu.sv
module move_alu_fu
    import move_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opnd_we,
    input  logic [DATA_W-1:0] opnd_data,
    input  logic              trig_we,
    input  alu_op_e           trig_op,
    input  logic [DATA_W-1:0] trig_data,
    output logic [DATA_W-1:0] operand_q_o,
    output logic [DATA_W-1:0] result_q_o
);

    typedef struct packed {
        logic [DATA_W-1:0] operand;
        logic [DATA_W-1:0] result;
    } fu_state_t;

    fu_state_t st_d, st_q;
    logic [DATA_W-1:0] operand_eff;

    always_comb begin
        st_d        = st_q;
        // a same-cycle operand write is forwarded into the triggered op
        operand_eff = opnd_we ? opnd_data : st_q.operand;
        st_d.operand = operand_eff;
        if (trig_we) begin
            unique case (trig_op)
                OP_ADD: st_d.result = operand_eff + trig_data;
                OP_SUB: st_d.result = operand_eff - trig_data;
                OP_AND: st_d.result = operand_eff & trig_data;
                OP_OR:  st_d.result = operand_eff | trig_data;
                default: st_d.result = st_q.result;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign operand_q_o = st_q.operand;
    assign result_q_o  = st_q.result;

    // R6: result only moves on a trigger
    p_result_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_we |=> $stable(result_q_o));

    // R8: operand only moves on an operand write
    p_operand_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_we |=> $stable(operand_q_o));

    // R7: a same-cycle operand write feeds the add
    p_add_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && opnd_we && trig_op == OP_ADD) |=>
            (result_q_o == $past(opnd_data) + $past(trig_data)));

    // R5: add with a held operand
    p_add_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && !opnd_we && trig_op == OP_ADD) |=>
            (result_q_o == $past(operand_q_o) + $past(trig_data)));

endmodule

// File: rtl/move_socket_net.sv
module move_socket_net
    import move_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_BUS  = 2,
    parameter int NUM_REGS = 8,
    localparam int RA_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [NUM_BUS-1:0]                slot_valid,
    input  logic [NUM_BUS-1:0][SEL_W-1:0]     slot_src,
    input  logic [NUM_BUS-1:0][SEL_W-1:0]     slot_dst,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]    slot_imm,
    output logic [NUM_BUS-1:0][RA_W-1:0]      rf_rd_addr,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]    rf_rd_data,
    input  logic [DATA_W-1:0]                 operand_q,
    input  logic [DATA_W-1:0]                 result_q,
    output logic [NUM_BUS-1:0]                rf_wr_en,
    output logic [NUM_BUS-1:0][RA_W-1:0]      rf_wr_addr,
    output logic [NUM_BUS-1:0][DATA_W-1:0]    rf_wr_data,
    output logic                              opnd_we,
    output logic [DATA_W-1:0]                 opnd_data,
    output logic                              trig_we,
    output alu_op_e                           trig_op,
    output logic [DATA_W-1:0]                 trig_data,
    output logic                              clash
);

    logic [NUM_BUS-1:0][DATA_W-1:0] bus_data;
    logic [NUM_REGS-1:0]            reg_hit;

    // Source sockets: each bus drives exactly one source onto its wires.
    always_comb begin
        for (int b = 0; b < NUM_BUS; b++) begin
            rf_rd_addr[b] = slot_src[b][RA_W-1:0];
            if (int'(slot_src[b]) < NUM_REGS) begin
                bus_data[b] = rf_rd_data[b];
            end else if (slot_src[b] == SRC_RESULT) begin
                bus_data[b] = result_q;
            end else if (slot_src[b] == SRC_OPERAND) begin
                bus_data[b] = operand_q;
            end else if (slot_src[b] == SRC_IMM) begin
                bus_data[b] = slot_imm[b];
            end else begin
                bus_data[b] = '0;
            end
        end
    end

    // Destination sockets: later buses overwrite earlier ones.
    always_comb begin
        opnd_we   = 1'b0;
        opnd_data = '0;
        trig_we   = 1'b0;
        trig_op   = OP_ADD;
        trig_data = '0;
        clash     = 1'b0;
        reg_hit   = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            rf_wr_en[b]   = 1'b0;
            rf_wr_addr[b] = slot_dst[b][RA_W-1:0];
            rf_wr_data[b] = bus_data[b];
            if (slot_valid[b]) begin
                unique case (classify_dst(slot_dst[b], NUM_REGS))
                    DK_REG: begin
                        rf_wr_en[b] = 1'b1;
                        if (reg_hit[rf_wr_addr[b]]) clash = 1'b1;
                        reg_hit[rf_wr_addr[b]] = 1'b1;
                    end
                    DK_OPERAND: begin
                        if (opnd_we) clash = 1'b1;
                        opnd_we   = 1'b1;
                        opnd_data = bus_data[b];
                    end
                    DK_TRIGGER: begin
                        if (trig_we) clash = 1'b1;
                        trig_we   = 1'b1;
                        trig_op   = alu_op_e'(slot_dst[b][1:0]);
                        trig_data = bus_data[b];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/move_datapath.sv
module move_datapath
    import move_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_BUS  = 2,
    parameter int NUM_REGS = 8,    // at most 16: codes 16 and up are unit sockets
    localparam int RA_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BUS-1:0]           slot_valid,
    input  logic [NUM_BUS*SEL_W-1:0]     slot_src,
    input  logic [NUM_BUS*SEL_W-1:0]     slot_dst,
    input  logic [NUM_BUS*DATA_W-1:0]    slot_imm,
    input  logic [RA_W-1:0]              dbg_addr,
    output logic [DATA_W-1:0]            dbg_data,
    output logic                         conflict
);

    typedef struct packed {
        logic conflict;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_BUS-1:0][SEL_W-1:0]  src_v, dst_v;
    logic [NUM_BUS-1:0][DATA_W-1:0] imm_v;
    logic [NUM_BUS-1:0][RA_W-1:0]   rd_addr, wr_addr;
    logic [NUM_BUS-1:0][DATA_W-1:0] rd_data, wr_data;
    logic [NUM_BUS-1:0]             wr_en;
    logic                           opnd_we, trig_we, clash;
    logic [DATA_W-1:0]              opnd_data, trig_data, operand_q, result_q;
    alu_op_e                        trig_op;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_unpack
        assign src_v[b] = slot_src[b*SEL_W +: SEL_W];
        assign dst_v[b] = slot_dst[b*SEL_W +: SEL_W];
        assign imm_v[b] = slot_imm[b*DATA_W +: DATA_W];
    end

    move_socket_net #(
        .DATA_W   (DATA_W),
        .NUM_BUS  (NUM_BUS),
        .NUM_REGS (NUM_REGS)
    ) u_net (
        .slot_valid (slot_valid),
        .slot_src   (src_v),
        .slot_dst   (dst_v),
        .slot_imm   (imm_v),
        .rf_rd_addr (rd_addr),
        .rf_rd_data (rd_data),
        .operand_q  (operand_q),
        .result_q   (result_q),
        .rf_wr_en   (wr_en),
        .rf_wr_addr (wr_addr),
        .rf_wr_data (wr_data),
        .opnd_we    (opnd_we),
        .opnd_data  (opnd_data),
        .trig_we    (trig_we),
        .trig_op    (trig_op),
        .trig_data  (trig_data),
        .clash      (clash)
    );

    move_regfile #(
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .NUM_PORTS (NUM_BUS)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    move_alu_fu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .clk         (clk),
        .rst_n       (rst_n),
        .opnd_we     (opnd_we),
        .opnd_data   (opnd_data),
        .trig_we     (trig_we),
        .trig_op     (trig_op),
        .trig_data   (trig_data),
        .operand_q_o (operand_q),
        .result_q_o  (result_q)
    );

    always_comb begin
        st_d          = st_q;
        st_d.conflict = clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conflict = st_q.conflict;

    // R9: a clash needs at least two valid moves in the previous cycle
    p_conflict_needs_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($past($countones(slot_valid)) >= 2));

    // R10: an idle cycle never produces a conflict pulse
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == '0) |=> !conflict);

endmodule

// File: tb/sim_move_datapath.sv
`timescale 1ns/1ps
module sim_move_datapath;

    localparam int DW = 16;
    localparam int NB = 2;
    localparam int NR = 8;
    localparam int SW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB-1:0]     slot_valid;
    logic [NB*SW-1:0]  slot_src, slot_dst;
    logic [NB*DW-1:0]  slot_imm;
    logic [2:0]        dbg_addr;
    logic [DW-1:0]     dbg_data;
    logic              conflict;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    move_datapath #(.DATA_W(DW), .NUM_BUS(NB), .NUM_REGS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_src(slot_src),
        .slot_dst(slot_dst), .slot_imm(slot_imm), .dbg_addr(dbg_addr),
        .dbg_data(dbg_data), .conflict(conflict)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_slots();
        slot_valid = '0;
        slot_src   = '0;
        slot_dst   = '0;
        slot_imm   = '0;
    endtask

    task automatic set_move(input int b, input logic [SW-1:0] s, input logic [SW-1:0] d,
                            input logic [DW-1:0] im);
        slot_valid[b]          = 1'b1;
        slot_src[b*SW +: SW]   = s;
        slot_dst[b*SW +: SW]   = d;
        slot_imm[b*DW +: DW]   = im;
    endtask

    // one clock edge, then back at the falling edge with idle slots
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_slots();
    endtask

    task automatic peek(input int r, output logic [DW-1:0] v);
        dbg_addr = 3'(r);
        #1;
        v = dbg_data;
    endtask

    task automatic expect_reg(input string req, input int r, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        peek(r, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++) expect_reg("R1 reg zero", r, 16'h0);
        check("R1 conflict low", {15'h0, conflict}, 16'h0);
        set_move(0, 5'd16, 5'd1, 16'h0);   // result -> r1
        set_move(1, 5'd17, 5'd2, 16'h0);   // operand -> r2
        step();
        expect_reg("R1 result zero", 1, 16'h0);
        expect_reg("R1 operand zero", 2, 16'h0);
    endtask

    task automatic t_imm_write();
        set_move(0, 5'd31, 5'd3, 16'h1234);
        step();
        expect_reg("R2 imm to reg", 3, 16'h1234);
    endtask

    task automatic t_parallel();
        set_move(0, 5'd31, 5'd0, 16'd5);
        set_move(1, 5'd31, 5'd1, 16'd7);
        step();
        expect_reg("R11 bus0 move", 0, 16'd5);
        expect_reg("R11 bus1 move", 1, 16'd7);
        check("R11 no conflict", {15'h0, conflict}, 16'h0);
    endtask

    task automatic t_swap();
        set_move(0, 5'd0, 5'd1, 16'h0);
        set_move(1, 5'd1, 5'd0, 16'h0);
        step();
        expect_reg("R3 swap r0", 0, 16'd7);
        expect_reg("R3 swap r1", 1, 16'd5);
    endtask

    task automatic t_ops();
        set_move(0, 5'd31, 5'd16, 16'd10);  // operand = 10
        step();
        set_move(0, 5'd17, 5'd4, 16'h0);
        step();
        expect_reg("R4 operand readback", 4, 16'd10);
        set_move(0, 5'd31, 5'd20, 16'd3);   // ADD
        step();
        set_move(0, 5'd16, 5'd4, 16'h0);
        step();
        expect_reg("R5 add", 4, 16'd13);
        set_move(0, 5'd31, 5'd21, 16'd4);   // SUB
        step();
        set_move(0, 5'd16, 5'd4, 16'h0);
        step();
        expect_reg("R5 sub", 4, 16'd6);
        set_move(0, 5'd31, 5'd22, 16'h000C); // AND
        step();
        set_move(0, 5'd16, 5'd4, 16'h0);
        step();
        expect_reg("R8 R5 and on held operand", 4, 16'd8);
        set_move(0, 5'd31, 5'd23, 16'h0005); // OR
        step();
        set_move(0, 5'd16, 5'd4, 16'h0);
        step();
        expect_reg("R8 R5 or on held operand", 4, 16'd15);
    endtask

    task automatic t_read_during_trigger();
        set_move(0, 5'd31, 5'd20, 16'd1);   // 10 + 1
        set_move(1, 5'd16, 5'd5, 16'h0);    // same-cycle result read
        step();
        expect_reg("R6 old result", 5, 16'd15);
        set_move(1, 5'd16, 5'd6, 16'h0);
        step();
        expect_reg("R6 new result", 6, 16'd11);
    endtask

    task automatic t_operand_bypass();
        set_move(0, 5'd31, 5'd16, 16'd100);
        set_move(1, 5'd31, 5'd20, 16'd1);
        step();
        set_move(0, 5'd16, 5'd7, 16'h0);
        set_move(1, 5'd17, 5'd0, 16'h0);
        step();
        expect_reg("R7 new operand used", 7, 16'd101);
        expect_reg("R7 operand latched", 0, 16'd100);
    endtask

    task automatic t_conflict();
        set_move(0, 5'd31, 5'd2, 16'h00AA);
        set_move(1, 5'd31, 5'd2, 16'h00BB);
        step();
        expect_reg("R9 higher bus wins reg", 2, 16'h00BB);
        check("R9 conflict raised", {15'h0, conflict}, 16'h1);
        step();
        check("R9 conflict one cycle", {15'h0, conflict}, 16'h0);
        set_move(0, 5'd31, 5'd20, 16'd1);   // ADD loses
        set_move(1, 5'd31, 5'd21, 16'd1);   // SUB wins: 100 - 1
        step();
        check("R9 trigger clash flagged", {15'h0, conflict}, 16'h1);
        set_move(0, 5'd16, 5'd3, 16'h0);
        step();
        expect_reg("R9 higher bus trigger", 3, 16'd99);
    endtask

    task automatic t_ignore();
        slot_valid = '0;
        slot_src[0 +: SW] = 5'd31;
        slot_dst[0 +: SW] = 5'd2;
        slot_imm[0 +: DW] = 16'hDEAD;
        slot_src[SW +: SW] = 5'd31;
        slot_dst[SW +: SW] = 5'd20;
        slot_imm[DW +: DW] = 16'h0100;
        step();
        expect_reg("R10 invalid no write", 2, 16'h00BB);
        set_move(0, 5'd16, 5'd4, 16'h0);
        step();
        expect_reg("R10 invalid no trigger", 4, 16'd99);
        set_move(0, 5'd31, 5'd30, 16'h5555);
        set_move(1, 5'd31, 5'd30, 16'h6666);
        step();
        check("R10 discard no conflict", {15'h0, conflict}, 16'h0);
        for (int r = 0; r < NR; r++) begin
            logic [DW-1:0] v;
            peek(r, v);
            check("R10 discard leaves regs", {15'h0, (v == 16'h5555 || v == 16'h6666)}, 16'h0);
        end
        set_move(0, 5'd25, 5'd3, 16'h7777);
        step();
        expect_reg("R10 unknown source zero", 3, 16'h0);
    endtask

    initial begin
        clear_slots();
        dbg_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm_write();
        t_parallel();
        t_swap();
        t_ops();
        t_read_during_trigger();
        t_operand_bypass();
        t_conflict();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule